// File: doc/BRIEF.md
# Sliding-Window Voltage Steady-State Detector

This block watches up to three voltage channels, each delivering one half-cycle RMS value per strobe. For every channel it keeps the most recent N values, where N is 100 at 50 Hz or 120 at 60 Hz, which is about one second. From that window it produces the arithmetic mean and a steady-state flag. A combined flag for polyphase use is the AND of the flags of the enabled channels. The RMS values, the nominal voltage and the per-mille threshold and hysteresis settings all come from outside the block. The block does not compute RMS values, measure frequency or produce timestamps.

The flag has asymmetric hysteresis. A steady channel drops its flag as soon as one new value differs from the mean of the preceding window by more than the full threshold. A channel that is not steady waits until a complete window of fresh values has been collected. After every strobe from then on, a sequential scan checks each stored value against the new mean using the narrower band, which is the threshold minus the hysteresis. The flag is set when every value passes. Strobes are expected at least N+3 clock cycles apart, which is far below one half-cycle of the mains frequency. A strobe that arrives while a channel is still busy with the previous value is not taken.

Top module: `steady_state_mon`

## Requirements
- R1: While reset is held and right after it is released, every channel flag, the combined flag and every channel mean are zero.
- R2: With mode60_i low, a channel flag stays low until 100 values have been collected. With 100 equal values, it goes high once the scan after the 100th strobe has finished.
- R3: With mode60_i high, the window is 120 values long: 119 equal values leave the flag low and the 120th sets it.
- R4: mean_o for a channel equals floor(sum of the last N values / N). It changes only on the second rising edge counting from the edge that samples the strobe.
- R5: A steady channel clears its flag on the edge that samples the strobe when |value - mean of the preceding window| * 1000 > thr_pm_i * nom_i. A deviation exactly equal to the threshold does not clear the flag.
- R6: A step to 97 % of nominal, and a ramp from 100 % down to 92 % over 200 values followed by a ramp back up, never clear the flag (defaults: threshold 50 per mille, hysteresis 25 per mille).
- R7: Once a flag has been cleared, it stays low for the next N-1 values and can rise only after the value that completes a fresh window. A rise never happens on the edge that samples a strobe.
- R8: The flag is restored only when every value in the fresh window satisfies |value - mean| * 1000 <= (thr_pm_i - hyst_pm_i) * nom_i, with the band taken as zero when the hysteresis is not below the threshold.
- R9: steady_all_o is high only when at least one channel is enabled in ch_en_i and every enabled channel is steady. A channel whose enable bit is low has its flag held low and restarts empty.
- R10: A change of mode60_i restarts every channel: all flags are low one edge later, and a new full window is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode60_i | input | 1 | 0: 100-value window, 1: 120-value window |
| ch_en_i | input | NUM_CH | Per-channel enable |
| nom_i | input | DATA_W | Declared nominal voltage, same scale as the samples |
| thr_pm_i | input | PM_W | Threshold in per mille of nominal |
| hyst_pm_i | input | PM_W | Hysteresis in per mille of nominal |
| strobe_i | input | 1 | One-cycle pulse: a new value is present on every channel |
| sample_i | input | NUM_CH*DATA_W | Half-cycle RMS values, channel 0 in the low bits |
| steady_o | output | NUM_CH | Per-channel steady-state flag |
| steady_all_o | output | 1 | AND of the flags of the enabled channels |
| mean_o | output | NUM_CH*DATA_W | Per-channel window mean, channel 0 in the low bits |

## Verification
Each result has its own latency, counted from the rising edge that samples the strobe. A clearing deviation lowers the flag on that same edge. The mean follows one edge later. A restored flag appears N+1 edges later, after the scan of all N entries. The bench spaces its strobes 128 cycles apart, which is longer than the longest of these latencies for either window length, and it reads every output on a falling edge just before the next strobe. The checks for R2, R3 and R7 use counts one short of a full window and then exactly a full window, which pins the fresh-window rule to the exact value.

// File: rtl/svsd_pkg.sv
package svsd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_MEAN,
    PH_SCAN
  } phase_e;

  // ceil(2^sh / n), used as a fixed-point reciprocal
  function automatic logic [63:0] recip_of(int unsigned n, int unsigned sh);
    logic [63:0] one;
    one = 64'd1 << sh;
    return (one + 64'(n) - 64'd1) / 64'(n);
  endfunction

endpackage

// File: rtl/svsd_dev_cmp.sv
module svsd_dev_cmp #(
  parameter int DATA_W = 16,
  parameter int PM_W   = 10
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] nom_i,
  input  logic [PM_W-1:0]   pm_i,
  output logic              beyond_o
);
  localparam int PROD_W = DATA_W + PM_W + 1;

  logic [DATA_W-1:0] dev;
  logic [PROD_W-1:0] lhs, rhs;

  always_comb begin
    dev      = (a_i >= b_i) ? (a_i - b_i) : (b_i - a_i);
    lhs      = PROD_W'(dev) * PROD_W'(1000);
    rhs      = PROD_W'(pm_i) * PROD_W'(nom_i);
    beyond_o = lhs > rhs;
  end
endmodule

// File: rtl/svsd_recip_div.sv
module svsd_recip_div #(
  parameter int DATA_W  = 16,
  parameter int SUM_W   = 23,
  parameter int SHIFT   = 30,
  parameter int RECIP_W = 31
) (
  input  logic [SUM_W-1:0]   sum_i,
  input  logic [RECIP_W-1:0] recip_i,
  output logic [DATA_W-1:0]  mean_o
);
  localparam int PROD_W = SUM_W + RECIP_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod   = PROD_W'(sum_i) * PROD_W'(recip_i);
    mean_o = DATA_W'(prod >> SHIFT);
  end
endmodule

// File: rtl/svsd_window.sv
module svsd_window #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 120,
  parameter int CNT_W  = 7,
  parameter int SUM_W  = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [CNT_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [SUM_W-1:0]  sum_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  ptr_q, fill_q;
  logic [SUM_W-1:0]  sum_q;
  logic              full;
  logic [DATA_W-1:0] oldest;

  assign full      = (fill_q == len_i);
  assign oldest    = full ? mem[ptr_q[IDX_W-1:0]] : '0;
  assign rd_data_o = mem[rd_idx_i[IDX_W-1:0]];
  assign sum_o     = sum_q;

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) mem[ptr_q[IDX_W-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      fill_q <= '0;
      sum_q  <= '0;
    end else if (clr_i) begin
      ptr_q  <= '0;
      fill_q <= '0;
      sum_q  <= '0;
    end else if (wr_i) begin
      ptr_q  <= (ptr_q == len_i - CNT_W'(1)) ? '0 : ptr_q + CNT_W'(1);
      fill_q <= full ? fill_q : fill_q + CNT_W'(1);
      // incremental update: add newest, drop oldest
      sum_q  <= sum_q + SUM_W'(din_i) - SUM_W'(oldest);
    end
  end
endmodule

// File: rtl/svsd_channel.sv
module svsd_channel
  import svsd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PM_W    = 10,
  parameter int DEPTH   = 120,
  parameter int CNT_W   = 7,
  parameter int SUM_W   = 23,
  parameter int SHIFT   = 30,
  parameter int RECIP_W = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               restart_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic [RECIP_W-1:0] recip_i,
  input  logic [DATA_W-1:0]  nom_i,
  input  logic [PM_W-1:0]    thr_pm_i,
  input  logic [PM_W-1:0]    band_pm_i,
  input  logic               strobe_i,
  input  logic [DATA_W-1:0]  sample_i,
  output logic               steady_o,
  output logic [DATA_W-1:0]  mean_o
);
  phase_e            phase_q;
  logic              steady_q, ok_q;
  logic [CNT_W-1:0]  fresh_q, idx_q;
  logic [DATA_W-1:0] mean_q, div_mean, rd_data;
  logic [SUM_W-1:0]  sum;
  logic              clr, take, jump, off_band;

  assign clr  = restart_i | ~en_i;
  assign take = strobe_i & (phase_q == PH_IDLE) & ~clr;

  svsd_window #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .SUM_W(SUM_W)
  ) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .wr_i     (take),
    .len_i    (len_i),
    .din_i    (sample_i),
    .rd_idx_i (idx_q),
    .rd_data_o(rd_data),
    .sum_o    (sum)
  );

  svsd_recip_div #(
    .DATA_W(DATA_W), .SUM_W(SUM_W), .SHIFT(SHIFT), .RECIP_W(RECIP_W)
  ) u_div (
    .sum_i  (sum),
    .recip_i(recip_i),
    .mean_o (div_mean)
  );

  // full threshold, new value against mean of preceding window
  svsd_dev_cmp #(.DATA_W(DATA_W), .PM_W(PM_W)) u_jump (
    .a_i(sample_i), .b_i(mean_q), .nom_i(nom_i), .pm_i(thr_pm_i), .beyond_o(jump)
  );

  // reduced band, stored value against fresh mean
  svsd_dev_cmp #(.DATA_W(DATA_W), .PM_W(PM_W)) u_band (
    .a_i(rd_data), .b_i(mean_q), .nom_i(nom_i), .pm_i(band_pm_i), .beyond_o(off_band)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      steady_q <= 1'b0;
      ok_q     <= 1'b0;
      fresh_q  <= '0;
      idx_q    <= '0;
      mean_q   <= '0;
    end else if (clr) begin
      phase_q  <= PH_IDLE;
      steady_q <= 1'b0;
      ok_q     <= 1'b0;
      fresh_q  <= '0;
      idx_q    <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (strobe_i) begin
            phase_q <= PH_MEAN;
            if (steady_q && jump) begin
              steady_q <= 1'b0;
              fresh_q  <= CNT_W'(1);
            end else if (fresh_q != len_i) begin
              fresh_q <= fresh_q + CNT_W'(1);
            end
          end
        end
        PH_MEAN: begin
          mean_q <= div_mean;
          if (!steady_q && fresh_q == len_i) begin
            phase_q <= PH_SCAN;
            idx_q   <= '0;
            ok_q    <= 1'b1;
          end else begin
            phase_q <= PH_IDLE;
          end
        end
        PH_SCAN: begin
          if (idx_q == len_i - CNT_W'(1)) begin
            steady_q <= ok_q & ~off_band;
            phase_q  <= PH_IDLE;
          end else begin
            ok_q  <= ok_q & ~off_band;
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign steady_o = steady_q;
  assign mean_o   = mean_q;
endmodule

// File: rtl/steady_state_mon.sv
module steady_state_mon #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 16,
  parameter int PM_W   = 10,
  parameter int WIN_50 = 100,
  parameter int WIN_60 = 120
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mode60_i,
  input  logic [NUM_CH-1:0]        ch_en_i,
  input  logic [DATA_W-1:0]        nom_i,
  input  logic [PM_W-1:0]          thr_pm_i,
  input  logic [PM_W-1:0]          hyst_pm_i,
  input  logic                     strobe_i,
  input  logic [NUM_CH*DATA_W-1:0] sample_i,
  output logic [NUM_CH-1:0]        steady_o,
  output logic                     steady_all_o,
  output logic [NUM_CH*DATA_W-1:0] mean_o
);
  localparam int DEPTH   = (WIN_50 > WIN_60) ? WIN_50 : WIN_60;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int SUM_W   = DATA_W + CNT_W;
  localparam int SHIFT   = SUM_W + CNT_W;
  localparam int RECIP_W = SHIFT + 1;
  localparam logic [RECIP_W-1:0] RECIP_50 = RECIP_W'(svsd_pkg::recip_of(WIN_50, SHIFT));
  localparam logic [RECIP_W-1:0] RECIP_60 = RECIP_W'(svsd_pkg::recip_of(WIN_60, SHIFT));

  logic               mode_q, restart;
  logic [CNT_W-1:0]   len;
  logic [RECIP_W-1:0] recip;
  logic [PM_W-1:0]    band_pm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode60_i;
  end

  assign restart = mode60_i ^ mode_q;
  assign len     = mode60_i ? CNT_W'(WIN_60) : CNT_W'(WIN_50);
  assign recip   = mode60_i ? RECIP_60 : RECIP_50;
  assign band_pm = (thr_pm_i > hyst_pm_i) ? (thr_pm_i - hyst_pm_i) : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    svsd_channel #(
      .DATA_W(DATA_W), .PM_W(PM_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
      .SUM_W(SUM_W), .SHIFT(SHIFT), .RECIP_W(RECIP_W)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (ch_en_i[c]),
      .restart_i(restart),
      .len_i    (len),
      .recip_i  (recip),
      .nom_i    (nom_i),
      .thr_pm_i (thr_pm_i),
      .band_pm_i(band_pm),
      .strobe_i (strobe_i),
      .sample_i (sample_i[c*DATA_W +: DATA_W]),
      .steady_o (steady_o[c]),
      .mean_o   (mean_o[c*DATA_W +: DATA_W])
    );
  end

  assign steady_all_o = (|ch_en_i) & (&(steady_o | ~ch_en_i));
endmodule

// File: rtl/steady_state_mon_chk.sv
module steady_state_mon_chk #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     mode60_i,
  input logic [NUM_CH-1:0]        ch_en_i,
  input logic                     strobe_i,
  input logic [NUM_CH-1:0]        steady_o,
  input logic                     steady_all_o,
  input logic [NUM_CH*DATA_W-1:0] mean_o
);
  AST_ALL_NEEDS_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steady_all_o |-> (ch_en_i != '0) && ((steady_o | ~ch_en_i) == '1)); // R9

  AST_MODE_SWITCH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode60_i != $past(mode60_i)) |=> (steady_o == '0)); // R10

  AST_MEAN_ONLY_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(strobe_i, 2) |-> $stable(mean_o)); // R4

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_RISE_NOT_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(steady_o[c]) |-> !$past(strobe_i)); // R7

    AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en_i[c] |=> !steady_o[c]); // R9

    AST_FALL_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(steady_o[c]) |-> $past(strobe_i) || !$past(ch_en_i[c]) ||
                            ($past(mode60_i) != $past(mode60_i, 2))); // R5
  end
endmodule

bind steady_state_mon steady_state_mon_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode60_i    (mode60_i),
  .ch_en_i     (ch_en_i),
  .strobe_i    (strobe_i),
  .steady_o    (steady_o),
  .steady_all_o(steady_all_o),
  .mean_o      (mean_o)
);

// File: tb/steady_state_mon_test.sv
module steady_state_mon_test;
  localparam int GAP = 128;
  localparam int T_N = 9;
  // count, value on every channel, expected flags, expected ch0 mean (-1: skip)
  localparam int    T_CNT  [T_N] = '{99, 1, 50, 50, 1, 98, 1, 1, 1};
  localparam int    T_VAL  [T_N] = '{10000, 10000, 9700, 10000, 9300, 9300, 9300, 9800, 9806};
  localparam int    T_ST   [T_N] = '{0, 7, 7, 7, 0, 0, 7, 7, 0};
  localparam int    T_MEAN [T_N] = '{-1, 10000, -1, 9850, 9846, -1, 9300, 9305, 9310};
  localparam string T_REQ  [T_N] = '{"R2", "R2", "R6", "R6", "R5", "R7", "R7", "R5", "R5"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode60 = 1'b0;
  logic [2:0]  ch_en = 3'b111;
  logic [15:0] nom = 16'd10000;
  logic [9:0]  thr = 10'd50;
  logic [9:0]  hyst = 10'd25;
  logic        strobe = 1'b0;
  logic [47:0] sample = '0;
  logic [2:0]  steady;
  logic        steady_all;
  logic [47:0] mean;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  steady_state_mon uut (
    .clk_i(clk), .rst_ni(rst_n), .mode60_i(mode60), .ch_en_i(ch_en),
    .nom_i(nom), .thr_pm_i(thr), .hyst_pm_i(hyst), .strobe_i(strobe),
    .sample_i(sample), .steady_o(steady), .steady_all_o(steady_all), .mean_o(mean)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(int v0, int v1, int v2);
    @(negedge clk);
    sample = {16'(v2), 16'(v1), 16'(v0)};
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    repeat (GAP - 1) @(negedge clk);
  endtask

  task automatic send_n(int n, int v);
    for (int k = 0; k < n; k++) send(v, v, v);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk("R1", "flags in reset", int'(steady), 0);
    chk("R1", "all in reset", int'(steady_all), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "mean after reset", int'(mean), 0);
    chk("R1", "all after reset", int'(steady_all), 0);

    // table walk: all channels see the same value
    for (int i = 0; i < T_N; i++) begin
      send_n(T_CNT[i], T_VAL[i]);
      chk(T_REQ[i], $sformatf("table row %0d flags", i), int'(steady), T_ST[i]);
      if (T_MEAN[i] >= 0) chk("R4", $sformatf("table row %0d mean", i), int'(mean[15:0]), T_MEAN[i]);
    end

    // R8: fresh window spread wider than reduced band stays low
    for (int i = 0; i < 100; i++) send_n(1, (i % 2 == 0) ? 9700 : 10300);
    chk("R8", "spread 300 flags", int'(steady), 0);
    chk("R4", "alternating mean", int'(mean[15:0]), 10000);
    for (int i = 0; i < 99; i++) send_n(1, (i % 2 == 0) ? 9780 : 10220);
    chk("R8", "one stale wide value left", int'(steady), 0);
    send_n(1, 10220);
    chk("R8", "spread 220 restores", int'(steady), 7);

    // R6: slow ramp down to 92 % and back never clears
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      send_n(1, 10000 - 4 * (i + 1));
      if (steady != 3'b111) bad++;
    end
    for (int i = 0; i < 200; i++) begin
      send_n(1, 9200 + 4 * (i + 1));
      if (steady != 3'b111) bad++;
    end
    chk("R6", "ramp strobes with flag low", bad, 0);
    send_n(10, 9700);
    chk("R6", "step to 97 percent", int'(steady), 7);

    // R9: polyphase combination
    send(10000, 9200, 10000);
    chk("R9", "one channel jumps", int'(steady), 5);
    chk("R9", "combined with jump", int'(steady_all), 0);
    ch_en = 3'b101;
    repeat (3) @(negedge clk);
    chk("R9", "combined ignores disabled", int'(steady_all), 1);
    chk("R9", "disabled flag", int'(steady), 5);
    ch_en = 3'b000;
    repeat (3) @(negedge clk);
    chk("R9", "none enabled flags", int'(steady), 0);
    chk("R9", "none enabled combined", int'(steady_all), 0);
    ch_en = 3'b111;
    repeat (2) @(negedge clk);
    send_n(100, 10000);
    chk("R9", "all steady again", int'(steady_all), 1);

    // R10 and R3: mode switch restarts with 120-value window
    mode60 = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "flags after mode switch", int'(steady), 0);
    send_n(119, 10000);
    chk("R3", "119 values", int'(steady), 0);
    send_n(1, 10000);
    chk("R3", "120 values", int'(steady), 7);
    chk("R4", "mean in 60 Hz mode", int'(mean[15:0]), 10000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule